// File: doc/BRIEF.md
# Duo-Binary Parity Encoder with Level Clamp and Puncturing

This block is the transmit-side front end of a two-bit-per-step turbo link. Each accepted step carries an information pair (a, b). A three-bit recursive state produces two parity bits, y and w, from that pair. The block then turns the four symbols a, b, y and w into 4-bit channel levels. A symbol of 1 takes one configured level and a symbol of 0 takes another. Any level above the ceiling 0111 is clamped to 0111. Last, a per-stream 12-position puncture pattern marks each symbol as kept or dropped.

Every accepted step gives exactly one output beat, one cycle later. The beat carries a level and a keep flag for each of the four streams. The beat is still produced when symbols are punctured. Those symbols are flagged and zeroed, so a downstream framer can remove them. The configuration inputs are the two levels and the four patterns. They are meant to be static while steps are flowing. They may change freely while the input is idle.

Top module: `duobin_punct_enc`

## Requirements
- R1: While reset is asserted and after its release, before any accepted step, `out_valid_o` is 0, every keep flag is 0, every level is 0000 and the recursive state (q1, q2, q3) is all zero.
- R2: The y symbol of a step equals a XOR b XOR q1 XOR q2 XOR q3, using the state held before that step.
- R3: The w symbol of a step equals a XOR b XOR q1 XOR q3, using the state held before that step. q2 has no part in w.
- R4: On each accepted step the state advances as q1 <= a^b^q1^q3, q2 <= q1^b, q3 <= q2^a.
- R5: The a and b streams carry the information bits of the step unchanged as symbols.
- R6: A symbol of 1 maps to the level on `lvl_one_i` and a symbol of 0 maps to the level on `lvl_zero_i`, before clamping.
- R7: A mapped level greater than 0111, read as unsigned, is output as 0111 (for example, 1000, 1100 and 1111 all become 0111).
- R8: A mapped level of 0111 or below is output unchanged.
- R9: A per-step position counter picks bit `pos` of each stream's 12-bit pattern, with bit 0 used for position 0. A 1 keeps the symbol and a 0 punctures it. The keep flag of the beat equals that bit.
- R10: The position counter starts at 0, advances by one on each accepted step and wraps from 11 back to 0.
- R11: A punctured symbol still appears in the beat (`out_valid_o` high), with its keep flag low and its level 0000. This applies even when its mapped level would have been clamped.
- R12: While `in_valid_i` is low, the state, the position counter, every level and every keep flag hold, and `out_valid_o` is low. Configuration changes made during that time do not alter the held outputs.
- R13: A step accepted at a rising edge with `in_valid_i` high produces its beat at that same edge. The beat is visible for exactly that one cycle with `out_valid_o` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Step accepted at this rising edge |
| a_i | input | 1 | First information bit |
| b_i | input | 1 | Second information bit |
| lvl_one_i | input | 4 | Level for a symbol of 1 |
| lvl_zero_i | input | 4 | Level for a symbol of 0 |
| pat_a_i | input | 12 | Keep pattern for stream a, bit n = position n |
| pat_b_i | input | 12 | Keep pattern for stream b |
| pat_y_i | input | 12 | Keep pattern for stream y |
| pat_w_i | input | 12 | Keep pattern for stream w |
| out_valid_o | output | 1 | Beat present |
| a_lvl_o | output | 4 | Level of stream a |
| a_keep_o | output | 1 | Stream a symbol kept |
| b_lvl_o | output | 4 | Level of stream b |
| b_keep_o | output | 1 | Stream b symbol kept |
| y_lvl_o | output | 4 | Level of stream y |
| y_keep_o | output | 1 | Stream y symbol kept |
| w_lvl_o | output | 4 | Level of stream w |
| w_keep_o | output | 1 | Stream w symbol kept |

## Verification
Clamping and puncturing can act on the same symbol in the same beat. Puncturing must win there: the output has to be 0000 with its keep flag low, not the clamped 0111. The bench provokes this with a 1-level of 1100 and patterns that hold zeros at several positions, among them position 11. Position 11 is where the counter wrap also happens, so a third event lands on the same beat. A scoreboard model predicts each beat. For every stream it compares the clamped, punctured or passed level, and the keep flag, with the design's output. The bench also inserts idle gaps at different counter positions, and changes the levels and patterns during those gaps. This checks that a pause freezes both the state and the puncture phase.

// File: rtl/ddb_pkg.sv
package ddb_pkg;
  localparam int NUM_STR = 4;
  localparam int IDX_A   = 0;
  localparam int IDX_B   = 1;
  localparam int IDX_Y   = 2;
  localparam int IDX_W   = 3;
  localparam int STATE_W = 3;

  typedef logic [NUM_STR-1:0] sym_vec_t;
  typedef logic [STATE_W-1:0] enc_state_t;
endpackage

// File: rtl/ddb_parity_enc.sv
module ddb_parity_enc
  import ddb_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     step_i,
  input  logic     a_i,
  input  logic     b_i,
  output sym_vec_t sym_o
);
  enc_state_t state_q;
  logic q1, q2, q3;

  assign q1 = state_q[0];
  assign q2 = state_q[1];
  assign q3 = state_q[2];

  always_comb begin
    sym_o        = '0;
    sym_o[IDX_A] = a_i;
    sym_o[IDX_B] = b_i;
    sym_o[IDX_Y] = a_i ^ b_i ^ q1 ^ q2 ^ q3;
    sym_o[IDX_W] = a_i ^ b_i ^ q1 ^ q3;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= '0;
    end else if (step_i) begin
      state_q[0] <= a_i ^ b_i ^ q1 ^ q3;
      state_q[1] <= q1 ^ b_i;
      state_q[2] <= q2 ^ a_i;
    end
  end

  // R12: an idle cycle must not disturb the recursion
  a_r12_state_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !step_i |=> $stable(state_q));

  // R3: q2 is not a term of w, so a change in q2 alone shows up only in y
  a_r3_w_ignores_q2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sym_o[IDX_Y] ^ sym_o[IDX_W]) == q2);
endmodule

// File: rtl/ddb_level_lim.sv
module ddb_level_lim
  import ddb_pkg::*;
#(
  parameter int LVL_W   = 4,
  parameter int LVL_MAX = 7
) (
  input  sym_vec_t                        sym_i,
  input  logic [LVL_W-1:0]                lvl_one_i,
  input  logic [LVL_W-1:0]                lvl_zero_i,
  output logic [NUM_STR-1:0][LVL_W-1:0]   lvl_o
);
  localparam logic [LVL_W-1:0] LIM = LVL_W'(LVL_MAX);

  for (genvar s = 0; s < NUM_STR; s++) begin : g_str
    logic [LVL_W-1:0] raw;
    assign raw      = sym_i[s] ? lvl_one_i : lvl_zero_i;
    assign lvl_o[s] = (raw > LIM) ? LIM : raw;
  end
endmodule

// File: rtl/ddb_puncture.sv
module ddb_puncture
  import ddb_pkg::*;
#(
  parameter int LVL_W    = 4,
  parameter int PUNC_LEN = 12
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             step_i,
  input  logic [NUM_STR-1:0][LVL_W-1:0]    lvl_i,
  input  logic [NUM_STR-1:0][PUNC_LEN-1:0] pat_i,
  output logic                             out_valid_o,
  output logic [NUM_STR-1:0]               keep_o,
  output logic [NUM_STR-1:0][LVL_W-1:0]    lvl_o
);
  localparam int POS_W = (PUNC_LEN > 1) ? $clog2(PUNC_LEN) : 1;
  localparam logic [POS_W-1:0] POS_LAST = POS_W'(PUNC_LEN - 1);

  logic [POS_W-1:0]              pos_q;
  logic [NUM_STR-1:0]            keep_d;
  logic [NUM_STR-1:0][LVL_W-1:0] lvl_d;

  for (genvar s = 0; s < NUM_STR; s++) begin : g_sel
    assign keep_d[s] = pat_i[s][pos_q];
    // puncture overrides whatever the limiter produced
    assign lvl_d[s]  = keep_d[s] ? lvl_i[s] : '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pos_q <= '0;
    end else if (step_i) begin
      pos_q <= (pos_q == POS_LAST) ? '0 : pos_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o <= 1'b0;
      keep_o      <= '0;
      lvl_o       <= '0;
    end else begin
      out_valid_o <= step_i;
      if (step_i) begin
        keep_o <= keep_d;
        lvl_o  <= lvl_d;
      end
    end
  end

  a_r10_pos_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pos_q <= POS_LAST);

  a_r10_pos_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && pos_q == POS_LAST) |=> pos_q == '0);

  a_r12_out_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !step_i |=> (!out_valid_o && $stable(lvl_o) && $stable(keep_o) && $stable(pos_q)));

  a_r13_beat_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i |=> out_valid_o);

  for (genvar s = 0; s < NUM_STR; s++) begin : g_chk
    a_r11_punct_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (out_valid_o && !keep_o[s]) |-> (lvl_o[s] == '0));
  end
endmodule

// File: rtl/duobin_punct_enc.sv
module duobin_punct_enc
  import ddb_pkg::*;
#(
  parameter int LVL_W    = 4,
  parameter int LVL_MAX  = 7,
  parameter int PUNC_LEN = 12
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                in_valid_i,
  input  logic                a_i,
  input  logic                b_i,
  input  logic [LVL_W-1:0]    lvl_one_i,
  input  logic [LVL_W-1:0]    lvl_zero_i,
  input  logic [PUNC_LEN-1:0] pat_a_i,
  input  logic [PUNC_LEN-1:0] pat_b_i,
  input  logic [PUNC_LEN-1:0] pat_y_i,
  input  logic [PUNC_LEN-1:0] pat_w_i,
  output logic                out_valid_o,
  output logic [LVL_W-1:0]    a_lvl_o,
  output logic                a_keep_o,
  output logic [LVL_W-1:0]    b_lvl_o,
  output logic                b_keep_o,
  output logic [LVL_W-1:0]    y_lvl_o,
  output logic                y_keep_o,
  output logic [LVL_W-1:0]    w_lvl_o,
  output logic                w_keep_o
);
  sym_vec_t                        sym;
  logic [NUM_STR-1:0][LVL_W-1:0]   lim_lvl;
  logic [NUM_STR-1:0][PUNC_LEN-1:0] pat;
  logic [NUM_STR-1:0]              keep_q;
  logic [NUM_STR-1:0][LVL_W-1:0]   lvl_q;

  assign pat[IDX_A] = pat_a_i;
  assign pat[IDX_B] = pat_b_i;
  assign pat[IDX_Y] = pat_y_i;
  assign pat[IDX_W] = pat_w_i;

  ddb_parity_enc u_enc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .step_i (in_valid_i),
    .a_i    (a_i),
    .b_i    (b_i),
    .sym_o  (sym)
  );

  ddb_level_lim #(
    .LVL_W   (LVL_W),
    .LVL_MAX (LVL_MAX)
  ) u_lim (
    .sym_i      (sym),
    .lvl_one_i  (lvl_one_i),
    .lvl_zero_i (lvl_zero_i),
    .lvl_o      (lim_lvl)
  );

  ddb_puncture #(
    .LVL_W    (LVL_W),
    .PUNC_LEN (PUNC_LEN)
  ) u_punc (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .step_i      (in_valid_i),
    .lvl_i       (lim_lvl),
    .pat_i       (pat),
    .out_valid_o (out_valid_o),
    .keep_o      (keep_q),
    .lvl_o       (lvl_q)
  );

  assign a_lvl_o  = lvl_q[IDX_A];
  assign b_lvl_o  = lvl_q[IDX_B];
  assign y_lvl_o  = lvl_q[IDX_Y];
  assign w_lvl_o  = lvl_q[IDX_W];
  assign a_keep_o = keep_q[IDX_A];
  assign b_keep_o = keep_q[IDX_B];
  assign y_keep_o = keep_q[IDX_Y];
  assign w_keep_o = keep_q[IDX_W];

  for (genvar s = 0; s < NUM_STR; s++) begin : g_ceil
    a_r7_level_ceiling: assert property (@(posedge clk_i) disable iff (!rst_ni)
      out_valid_o |-> (lvl_q[s] <= LVL_W'(LVL_MAX)));
  end
endmodule

// File: tb/duobin_punct_enc_test.sv
module duobin_punct_enc_test;
  typedef struct packed {
    logic [3:0][3:0] lvl;
    logic [3:0]      keep;
    logic [3:0]      clampf;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        in_valid = 1'b0;
  logic        a_in = 1'b0, b_in = 1'b0;
  logic [3:0]  lvl_one = 4'h7, lvl_zero = 4'h0;
  logic [11:0] pat_a = 12'hFFF, pat_b = 12'hFFF, pat_y = 12'hFFF, pat_w = 12'hFFF;
  logic        out_valid;
  logic [3:0]  a_lvl, b_lvl, y_lvl, w_lvl;
  logic        a_keep, b_keep, y_keep, w_keep;

  int n_cmp = 0;
  int n_bad = 0;
  bit started = 1'b0;
  bit finished = 1'b0;
  string phase = "init";

  // bench model
  logic [2:0] m_q = 3'b000;
  int         m_pos = 0;
  logic [15:0] lfsr = 16'hACE1;
  exp_t       exp_q[$];

  always #4 clk = ~clk;

  duobin_punct_enc uut (
    .clk_i(clk), .rst_ni(rst_ni), .in_valid_i(in_valid), .a_i(a_in), .b_i(b_in),
    .lvl_one_i(lvl_one), .lvl_zero_i(lvl_zero),
    .pat_a_i(pat_a), .pat_b_i(pat_b), .pat_y_i(pat_y), .pat_w_i(pat_w),
    .out_valid_o(out_valid),
    .a_lvl_o(a_lvl), .a_keep_o(a_keep), .b_lvl_o(b_lvl), .b_keep_o(b_keep),
    .y_lvl_o(y_lvl), .y_keep_o(y_keep), .w_lvl_o(w_lvl), .w_keep_o(w_keep)
  );

  logic [3:0][3:0] obs_lvl;
  logic [3:0]      obs_keep;
  assign obs_lvl  = {w_lvl, y_lvl, b_lvl, a_lvl};
  assign obs_keep = {w_keep, y_keep, b_keep, a_keep};

  task automatic check(string tag, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  function automatic logic [3:0] map_lvl(logic bitv, logic [3:0] one, logic [3:0] zero);
    logic [3:0] v;
    v = bitv ? one : zero;
    return (v > 4'd7) ? 4'd7 : v;
  endfunction

  // driver: one accepted step, expected beat pushed to the scoreboard
  task automatic step(logic a, logic b);
    exp_t e;
    logic [3:0] sym;
    logic [3:0][11:0] pats;
    logic q1, q2, q3;
    @(negedge clk);
    in_valid = 1'b1;
    a_in = a;
    b_in = b;
    q1 = m_q[0]; q2 = m_q[1]; q3 = m_q[2];
    sym[0] = a;
    sym[1] = b;
    sym[2] = a ^ b ^ q1 ^ q2 ^ q3;   // R2
    sym[3] = a ^ b ^ q1 ^ q3;        // R3
    pats = {pat_w, pat_y, pat_b, pat_a};
    for (int s = 0; s < 4; s++) begin
      logic [3:0] raw;
      raw = sym[s] ? lvl_one : lvl_zero;
      e.clampf[s] = (raw > 4'd7);
      e.keep[s]   = pats[s][m_pos];
      e.lvl[s]    = e.keep[s] ? map_lvl(sym[s], lvl_one, lvl_zero) : 4'd0;
    end
    exp_q.push_back(e);
    m_q = {q2 ^ a, q1 ^ b, a ^ b ^ q1 ^ q3};   // R4
    m_pos = (m_pos == 11) ? 0 : m_pos + 1;    // R10
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
    end
  endtask

  task automatic rand_steps(int n);
    for (int i = 0; i < n; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step(lfsr[0], lfsr[3]);
    end
  endtask

  // monitor: pops at the negedge after the accepting edge (R13)
  initial begin : monitor
    logic [3:0][3:0] prev_lvl;
    logic [3:0]      prev_keep;
    string sname[4];
    sname[0] = "R5 a"; sname[1] = "R5 b"; sname[2] = "R2/R4 y"; sname[3] = "R3/R4 w";
    prev_lvl = '0;
    prev_keep = '0;
    wait (started);
    forever begin
      @(negedge clk);
      if (out_valid === 1'b1) begin
        if (exp_q.size() == 0) begin
          check("R13 unexpected beat", 1, 0);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          for (int s = 0; s < 4; s++) begin
            string lt;
            lt = !e.keep[s] ? "R11" : (e.clampf[s] ? "R7" : "R8");
            check($sformatf("%s lvl %s [%s]", sname[s], lt, phase), int'(obs_lvl[s]), int'(e.lvl[s]));
            check($sformatf("%s keep R9 [%s]", sname[s], phase), int'(obs_keep[s]), int'(e.keep[s]));
          end
        end
        prev_lvl = obs_lvl;
        prev_keep = obs_keep;
      end else begin
        check($sformatf("R12 hold lvl [%s]", phase), int'(obs_lvl), int'(prev_lvl));
        check($sformatf("R12 hold keep [%s]", phase), int'(obs_keep), int'(prev_keep));
      end
    end
  end

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    check("watchdog expired", 1, 0);
    finish_run();
  end

  initial begin : main
    repeat (3) @(negedge clk);
    check("R1 reset out_valid", int'(out_valid), 0);
    check("R1 reset levels", int'(obs_lvl), 0);
    check("R1 reset keeps", int'(obs_keep), 0);
    rst_ni = 1'b1;
    @(negedge clk);
    check("R1 after release out_valid", int'(out_valid), 0);
    check("R1 after release levels", int'(obs_lvl), 0);
    started = 1'b1;

    // zero-state start: first step with a=1,b=0 gives y=w=1 (R1, R2, R3)
    phase = "R6 map, R1 state";
    step(1'b1, 1'b0);
    step(1'b0, 1'b0);
    step(1'b1, 1'b1);
    rand_steps(24);
    idle(2);

    // clamping of 1-level, 0-level passes
    phase = "R7 clamp one";
    lvl_one = 4'hC; lvl_zero = 4'h2;
    rand_steps(14);
    idle(1);
    // R12: config changes during idle must not move the held outputs
    lvl_one = 4'h8; lvl_zero = 4'hF;
    idle(2);
    phase = "R7 clamp both";
    rand_steps(14);
    idle(1);
    lvl_one = 4'h3; lvl_zero = 4'h7;
    idle(1);
    phase = "R8 pass";
    rand_steps(10);
    idle(2);

    // puncturing, with clamp and wrap colliding
    pat_a = 12'hFFE; pat_b = 12'hB3C; pat_y = 12'h6D7; pat_w = 12'h7F5;
    lvl_one = 4'hC; lvl_zero = 4'h1;
    idle(1);
    phase = "R9 R10 R11 punct+clamp";
    for (int k = 0; k < 5; k++) begin
      rand_steps(7);
      idle(2);
    end
    pat_a = 12'h000; pat_b = 12'hFFF; pat_y = 12'h555; pat_w = 12'hAAA;
    idle(1);
    phase = "R11 all-drop a";
    rand_steps(26);
    idle(3);

    check("R13 scoreboard drained", exp_q.size(), 0);
    finish_run();
  end
endmodule